// File: doc/BRIEF.md
# Programmable Output Macrocell Bank

This block models the output stage of a small programmable logic device. It is a bank of eight macrocells. Each macrocell receives a group of eight product terms from an AND array outside the block, along with a polarity bit and a direction bit. Each one produces a pin value, a pin output enable (the two together make the tri-state drive) and one feedback bit that goes back into the array. A pair of global configuration bits selects one of three bank-wide operating modes: combinational-only, combinational with per-pin enable terms, or registered. All configuration arrives on static inputs.

Two shared pins serve the bank. One carries the register clock and the other an active-low output enable. In the complex mode these two pins become ordinary inputs instead, and their levels enter the array on the feedback lines of the two end cells. The feedback routing depends on the mode. In registered mode a cell feeds back its own register or its own pin. In complex mode the end cells give up their feedback to the shared pins. In simple mode every feedback line carries the pin next to it, on the side toward the centre, and the two centre cells act as fixed outputs with no feedback.

Top module: `pld_olmc_bank`

## Requirements
- R1: Registered mode is `syn_bit`=0 with `ac0_bit`=1. In this mode, a cell whose direction bit is 0 holds a flip-flop. On each rising clock edge the flip-flop loads (OR of all eight of the cell's terms) XOR its polarity bit. The cell's `pin_out` is the inverted flip-flop value. Reset clears every flip-flop, so `pin_out` reads 1 after reset. In every other mode and configuration the flip-flop keeps its value.
- R2: In registered mode, a cell whose direction bit is 0 has `pin_oe` equal to the inverse of `oe_pin_n`.
- R3: In registered mode, a cell whose direction bit is 0 has `fb_out` equal to its flip-flop value.
- R4: Complex mode is `syn_bit`=1 with `ac0_bit`=1. In complex mode, and for cells with direction bit 1 in registered mode, `pin_oe` is term 0 of the cell. `pin_out` is (OR of terms 1 to 7) XOR the polarity bit. Term k of cell c is `pt_in[c*8+k]`.
- R5: In complex mode, `fb_out[0]` is `ck_pin_lvl` and `fb_out[7]` is `oe_pin_n`. Cells 1 to 6 feed back their own `pin_in`. In registered mode, a cell with direction bit 1 feeds back its own `pin_in`.
- R6: Simple mode is `syn_bit`=1 with `ac0_bit`=0. In simple mode an outer cell (0-2, 5-7) with direction bit 1 has `pin_oe`=0, and with direction bit 0 has `pin_oe`=1. In either case `pin_out` is (OR of all eight terms) XOR the polarity bit.
- R7: In simple mode cells 3 and 4 always have `pin_oe`=1 whatever their direction bit, and their `fb_out` is 0.
- R8: In simple mode, `fb_out[i]` is `pin_in[i+1]` for cells 0-2 and `pin_in[i-1]` for cells 5-7.
- R9: The unused code `syn_bit`=0 with `ac0_bit`=0 behaves exactly like simple mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock (shared clock pin) |
| rst_n | input | 1 | Asynchronous active-low reset of the flip-flops |
| syn_bit | input | 1 | Global mode bit, 0 selects registered when `ac0_bit`=1 |
| ac0_bit | input | 1 | Global mode bit |
| pol_bits | input | 8 | Per-cell output polarity |
| dir_bits | input | 8 | Per-cell direction / function bit |
| ck_pin_lvl | input | 1 | Level of the clock pin used as data in complex mode |
| oe_pin_n | input | 1 | Shared active-low enable pin level |
| pt_in | input | 64 | Product terms, eight per cell, cell c at bits c*8+7..c*8 |
| pin_in | input | 8 | Level seen on each pin |
| pin_out | output | 8 | Pin drive value |
| pin_oe | output | 8 | Pin driver enable |
| fb_out | output | 8 | Feedback lines into the array |

## Verification
The bench goes after the mode boundaries. A design that mixes up the feedback mapping would show the pin's own level in simple mode, or a cell's own pin in place of a shared pin in complex mode. The bench also checks that the centre cells stay enabled when their direction bit asks for input, and that a direction-1 cell in registered mode drops its flip-flop and becomes a term-enabled combinational cell. The flip-flop is tested across mode switches: it must hold outside registered mode and come back with its last value. The unused mode code must not fall through to registered or complex behaviour.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  typedef enum logic [1:0] {
    MODE_SIMPLE     = 2'd0,
    MODE_COMPLEX    = 2'd1,
    MODE_REGISTERED = 2'd2
  } bank_mode_e;

  // Global mode selection; the spare code falls back to simple.
  function automatic bank_mode_e decode_mode(input logic syn, input logic ac0);
    bank_mode_e m;
    unique case ({syn, ac0})
      2'b11:   m = MODE_COMPLEX;
      2'b01:   m = MODE_REGISTERED;
      default: m = MODE_SIMPLE;
    endcase
    return m;
  endfunction

  // Polarity stage shared by every data path.
  function automatic logic apply_pol(input logic sum, input logic pol);
    return sum ^ pol;
  endfunction

endpackage

// File: rtl/pld_mode_dec.sv
module pld_mode_dec
  import pld_mc_pkg::*;
(
  input  logic       syn_bit,
  input  logic       ac0_bit,
  output bank_mode_e mode,
  output logic       is_reg,
  output logic       is_cpx,
  output logic       is_smp
);

  always_comb begin
    mode   = decode_mode(syn_bit, ac0_bit);
    is_reg = (mode == MODE_REGISTERED);
    is_cpx = (mode == MODE_COMPLEX);
    is_smp = (mode == MODE_SIMPLE);
  end

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int NPT      = 8,
  parameter bit IS_INNER = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  bank_mode_e     mode,
  input  logic           pol,
  input  logic           dir,
  input  logic           oe_pin_n,
  input  logic [NPT-1:0] pt,
  output logic           pin_out,
  output logic           pin_oe,
  output logic           reg_q,
  output logic           cap_en
);

  logic sum_all;
  logic sum_tail;
  logic q;

  assign sum_all  = |pt;
  assign sum_tail = |pt[NPT-1:1];
  assign cap_en   = (mode == MODE_REGISTERED) && !dir;
  assign reg_q    = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (cap_en) begin
      q <= apply_pol(sum_all, pol);
    end
  end

  always_comb begin
    pin_out = apply_pol(sum_all, pol);
    pin_oe  = 1'b1;
    unique case (mode)
      MODE_REGISTERED: begin
        if (!dir) begin
          pin_out = ~q;
          pin_oe  = ~oe_pin_n;
        end else begin
          pin_out = apply_pol(sum_tail, pol);
          pin_oe  = pt[0];
        end
      end
      MODE_COMPLEX: begin
        pin_out = apply_pol(sum_tail, pol);
        pin_oe  = pt[0];
      end
      default: begin
        pin_out = apply_pol(sum_all, pol);
        pin_oe  = IS_INNER ? 1'b1 : !dir;
      end
    endcase
  end

endmodule

// File: rtl/pld_fb_router.sv
module pld_fb_router
  import pld_mc_pkg::*;
#(
  parameter int NCELL = 8
) (
  input  bank_mode_e       mode,
  input  logic [NCELL-1:0] dir_bits,
  input  logic [NCELL-1:0] pin_in,
  input  logic [NCELL-1:0] reg_q,
  input  logic             ck_pin_lvl,
  input  logic             oe_pin_n,
  output logic [NCELL-1:0] fb_out
);

  localparam int HALF = NCELL / 2;

  for (genvar i = 0; i < NCELL; i++) begin : g_fb
    logic cpx_src;
    logic smp_src;

    if (i == 0) begin : g_first
      assign cpx_src = ck_pin_lvl;
    end else if (i == NCELL - 1) begin : g_last
      assign cpx_src = oe_pin_n;
    end else begin : g_mid
      assign cpx_src = pin_in[i];
    end

    if (i == HALF - 1 || i == HALF) begin : g_inner
      assign smp_src = 1'b0;
    end else if (i < HALF) begin : g_low
      assign smp_src = pin_in[i+1];
    end else begin : g_high
      assign smp_src = pin_in[i-1];
    end

    always_comb begin
      unique case (mode)
        MODE_REGISTERED: fb_out[i] = dir_bits[i] ? pin_in[i] : reg_q[i];
        MODE_COMPLEX:    fb_out[i] = cpx_src;
        default:         fb_out[i] = smp_src;
      endcase
    end
  end

endmodule

// File: rtl/pld_olmc_bank.sv
module pld_olmc_bank
  import pld_mc_pkg::*;
#(
  parameter int NCELL = 8,
  parameter int NPT   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 syn_bit,
  input  logic                 ac0_bit,
  input  logic [NCELL-1:0]     pol_bits,
  input  logic [NCELL-1:0]     dir_bits,
  input  logic                 ck_pin_lvl,
  input  logic                 oe_pin_n,
  input  logic [NCELL*NPT-1:0] pt_in,
  input  logic [NCELL-1:0]     pin_in,
  output logic [NCELL-1:0]     pin_out,
  output logic [NCELL-1:0]     pin_oe,
  output logic [NCELL-1:0]     fb_out
);

  localparam int HALF = NCELL / 2;

  bank_mode_e       mode;
  logic             is_reg;
  logic             is_cpx;
  logic             is_smp;
  logic [NCELL-1:0] reg_q_vec;
  logic [NCELL-1:0] cap_en_vec;

  pld_mode_dec u_mode (
    .syn_bit (syn_bit),
    .ac0_bit (ac0_bit),
    .mode    (mode),
    .is_reg  (is_reg),
    .is_cpx  (is_cpx),
    .is_smp  (is_smp)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    pld_macrocell #(
      .NPT      (NPT),
      .IS_INNER ((c == HALF - 1) || (c == HALF))
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .pol      (pol_bits[c]),
      .dir      (dir_bits[c]),
      .oe_pin_n (oe_pin_n),
      .pt       (pt_in[c*NPT +: NPT]),
      .pin_out  (pin_out[c]),
      .pin_oe   (pin_oe[c]),
      .reg_q    (reg_q_vec[c]),
      .cap_en   (cap_en_vec[c])
    );
  end

  pld_fb_router #(
    .NCELL (NCELL)
  ) u_fb (
    .mode       (mode),
    .dir_bits   (dir_bits),
    .pin_in     (pin_in),
    .reg_q      (reg_q_vec),
    .ck_pin_lvl (ck_pin_lvl),
    .oe_pin_n   (oe_pin_n),
    .fb_out     (fb_out)
  );

endmodule

// File: rtl/pld_olmc_bank_chk.sv
module pld_olmc_bank_chk #(
  parameter int NCELL = 8,
  parameter int NPT   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 syn_bit,
  input logic                 ac0_bit,
  input logic                 is_reg,
  input logic                 is_cpx,
  input logic                 is_smp,
  input logic [NCELL-1:0]     cap_en_vec,
  input logic [NCELL-1:0]     pol_bits,
  input logic [NCELL-1:0]     dir_bits,
  input logic                 ck_pin_lvl,
  input logic                 oe_pin_n,
  input logic [NCELL*NPT-1:0] pt_in,
  input logic [NCELL-1:0]     pin_out,
  input logic [NCELL-1:0]     pin_oe,
  input logic [NCELL-1:0]     fb_out
);

  localparam int HALF = NCELL / 2;

  a_r9_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({is_reg, is_cpx, is_smp}) == 1));

  a_r9_default_simple: assert property (@(posedge clk) disable iff (!rst_n)
    (!syn_bit && !ac0_bit) |-> is_smp);

  a_r5_cpx_ends: assert property (@(posedge clk) disable iff (!rst_n)
    is_cpx |-> (fb_out[0] == ck_pin_lvl) && (fb_out[NCELL-1] == oe_pin_n));

  a_r7_inner_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    is_smp |-> pin_oe[HALF-1] && pin_oe[HALF] && !fb_out[HALF-1] && !fb_out[HALF]);

  for (genvar i = 0; i < NCELL; i++) begin : g_cell_chk
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en_vec[i] ##1 cap_en_vec[i] |->
        pin_out[i] == ~$past((|pt_in[i*NPT +: NPT]) ^ pol_bits[i]));

    a_r2_reg_oe: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en_vec[i] |-> pin_oe[i] == !oe_pin_n);

    a_r3_reg_fb: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en_vec[i] |-> fb_out[i] == !pin_out[i]);

    a_r4_cpx_oe: assert property (@(posedge clk) disable iff (!rst_n)
      is_cpx |-> pin_oe[i] == pt_in[i*NPT]);

    if (i != HALF - 1 && i != HALF) begin : g_outer
      a_r6_smp_input: assert property (@(posedge clk) disable iff (!rst_n)
        (is_smp && dir_bits[i]) |-> !pin_oe[i]);
    end
  end

endmodule

bind pld_olmc_bank pld_olmc_bank_chk #(
  .NCELL (NCELL),
  .NPT   (NPT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .syn_bit    (syn_bit),
  .ac0_bit    (ac0_bit),
  .is_reg     (is_reg),
  .is_cpx     (is_cpx),
  .is_smp     (is_smp),
  .cap_en_vec (cap_en_vec),
  .pol_bits   (pol_bits),
  .dir_bits   (dir_bits),
  .ck_pin_lvl (ck_pin_lvl),
  .oe_pin_n   (oe_pin_n),
  .pt_in      (pt_in),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .fb_out     (fb_out)
);

// File: tb/pld_olmc_bank_tb.sv
`timescale 1ns/1ps
module pld_olmc_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        syn_bit, ac0_bit;
  logic [7:0]  pol_bits, dir_bits, pin_in;
  logic        ck_pin_lvl, oe_pin_n;
  logic [7:0]  terms [8];
  logic [63:0] pt_in;
  logic [7:0]  pin_out, pin_oe, fb_out;

  int   errors = 0;
  int   checks = 0;
  bit   live   = 1'b0;
  bit   done   = 1'b0;
  logic [7:0] mq;

  always #5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < 8; c++) pt_in[c*8 +: 8] = terms[c];
  end

  pld_olmc_bank u_dut (
    .clk(clk), .rst_n(rst_n), .syn_bit(syn_bit), .ac0_bit(ac0_bit),
    .pol_bits(pol_bits), .dir_bits(dir_bits), .ck_pin_lvl(ck_pin_lvl),
    .oe_pin_n(oe_pin_n), .pt_in(pt_in), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  // Reference flip-flops, one per cell.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mq <= 8'h00;
    else if (!syn_bit && ac0_bit) begin
      for (int c = 0; c < 8; c++)
        if (!dir_bits[c]) mq[c] <= (terms[c] != 8'h00) ^ pol_bits[c];
    end
  end

  function automatic string tag_of(int c, string fld);
    bit r = !syn_bit && ac0_bit;
    bit x = syn_bit && ac0_bit;
    if (!syn_bit && !ac0_bit) return "R9";
    if (r && !dir_bits[c]) return (fld == "out") ? "R1" : (fld == "oe") ? "R2" : "R3";
    if (r || x) return (fld == "fb") ? "R5" : "R4";
    if (c == 3 || c == 4) return "R7";
    return (fld == "fb") ? "R8" : "R6";
  endfunction

  task automatic cmp(int c, string fld, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cell %0d %s: got %b expected %b at %0t",
               tag_of(c, fld), c, fld, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit r = !syn_bit && ac0_bit;
    bit x = syn_bit && ac0_bit;
    for (int c = 0; c < 8; c++) begin
      logic s_all, s_tail, e_out, e_oe, e_fb;
      s_all  = terms[c] != 8'h00;
      s_tail = terms[c][7:1] != 7'h00;
      if (r && !dir_bits[c]) begin
        e_out = ~mq[c]; e_oe = ~oe_pin_n; e_fb = mq[c];
      end else if (r || x) begin
        e_out = s_tail ^ pol_bits[c];
        e_oe  = terms[c][0];
        if (x && c == 0)      e_fb = ck_pin_lvl;
        else if (x && c == 7) e_fb = oe_pin_n;
        else                  e_fb = pin_in[c];
      end else begin
        e_out = s_all ^ pol_bits[c];
        if (c == 3 || c == 4) begin e_oe = 1'b1; e_fb = 1'b0; end
        else begin
          e_oe = !dir_bits[c];
          e_fb = (c < 4) ? pin_in[c+1] : pin_in[c-1];
        end
      end
      cmp(c, "out", pin_out[c], e_out);
      cmp(c, "oe",  pin_oe[c],  e_oe);
      cmp(c, "fb",  fb_out[c],  e_fb);
    end
  endtask

  always @(negedge clk) if (live) compare_all();

  task automatic randomize_inputs();
    for (int c = 0; c < 8; c++) begin
      // Sparse terms so both OR results occur often.
      terms[c] = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom) & 8'($urandom);
    end
    pol_bits   = 8'($urandom);
    dir_bits   = 8'($urandom);
    pin_in     = 8'($urandom);
    ck_pin_lvl = 1'($urandom);
    oe_pin_n   = 1'($urandom);
  endtask

  task automatic run_mode(logic s, logic a, int n);
    syn_bit = s; ac0_bit = a;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      randomize_inputs();
    end
  endtask

  initial begin
    rst_n = 1'b0; syn_bit = 1'b0; ac0_bit = 1'b1;
    pol_bits = 8'h0F; dir_bits = 8'h00; pin_in = 8'h00;
    ck_pin_lvl = 1'b0; oe_pin_n = 1'b0;
    for (int c = 0; c < 8; c++) terms[c] = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset leaves flip-flops cleared, so pins read high.
    checks++;
    if (pin_out !== 8'hFF) begin
      errors++;
      $display("FAIL R1 reset pin_out: got %h expected ff", pin_out);
    end
    live = 1'b1;
    rst_n = 1'b1;
    // R1: directed capture, all terms high, polarity 0F gives q=F0, pin=0F.
    @(posedge clk); #1;
    @(negedge clk);
    checks++;
    if (pin_out !== 8'h0F) begin
      errors++;
      $display("FAIL R1 capture pin_out: got %h expected 0f", pin_out);
    end
    run_mode(1'b0, 1'b1, 300);   // registered
    run_mode(1'b1, 1'b1, 200);   // complex, flip-flops must hold
    run_mode(1'b0, 1'b1, 100);   // registered again
    run_mode(1'b1, 1'b0, 200);   // simple
    run_mode(1'b0, 1'b0, 150);   // spare code (R9)
    // R7: centre cells with input request in simple mode, all terms zero.
    syn_bit = 1'b1; ac0_bit = 1'b0; dir_bits = 8'hFF; pol_bits = 8'h00;
    for (int c = 0; c < 8; c++) terms[c] = 8'h00;
    @(negedge clk);
    checks++;
    if (pin_oe !== 8'h18) begin
      errors++;
      $display("FAIL R7 simple enables: got %h expected 18", pin_oe);
    end
    run_mode(1'b0, 1'b1, 100);
    @(negedge clk);
    live = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule